// File: doc/BRIEF.md
# Configurable Bidirectional Port with Shared Interrupt

This block controls a parameterised group of general-purpose pins (eight by default). Software sets up each pin through three byte-wide registers: an output latch, a direction mask and an option mask. For each pin, the direction bit and the option bit together select one of four modes: floating input, input with pull-up and interrupt, open-drain output or push-pull output. The block drives per-pin output-enable, output-value and pull-up-enable signals toward an external pad model. It samples the pad levels through a two-flop synchronizer.

An on-chip peripheral can take over any pin through a per-pin alternate enable. That pin is then forced to drive the peripheral's output value, and it is removed from the interrupt logic. All pins in the pull-up/interrupt mode feed one shared interrupt source. A fourth register selects how that source raises the single interrupt request: on a falling event, on a rising event or on both, each latched, or as an unlatched low level.

The register port is plain control traffic, not a stream. A write is accepted in the cycle where `wr_en` is high, with no back-pressure. The read data is a combinational function of `addr`. Pad and interrupt signals are plain level signals.

Top module: `gpio_port`

## Requirements
- R1: After reset, every register reads 0, and `pad_oe_o`, `pad_pu_o` and `irq_o` are all 0 (every pin is a floating input).
- R2: With direction=0 and option=0, the pin is a floating input: output-enable and pull-up are 0, and the pin never contributes to the interrupt.
- R3: With direction=0 and option=1, the pin is an input with pull-up: pull-up=1, output-enable=0, and the pin takes part in the interrupt source.
- R4: With direction=1 and option=0, the pin is open-drain: output value 0, and output-enable is the inverse of the data bit.
- R5: With direction=1 and option=1, the pin is push-pull: output-enable=1, output value = data bit, pull-up=0. Pad output value is 0 for every pin that is not push-pull or alternate.
- R6: When `alt_en_i[i]`=1, pin i drives `alt_out_i[i]` with output-enable=1 and pull-up=0, and it is excluded from the interrupt source, whatever its registers hold.
- R7: Register map: address 0 = data, 1 = direction, 2 = option, 3 = interrupt control. Bits [1:0] of address 3 hold the sensitivity; its upper bits read 0. A read of address 0 returns the synchronized pad level for input pins, the data latch for register-output pins and the alternate value for alternate pins.
- R8: The shared source is active when any interrupt-enabled pin is synchronized low. A change at the pad reaches the source after two clocks.
- R9: Sensitivity 00 (falling): the source going active sets a latched request; the source going inactive does not.
- R10: Sensitivity 01 (rising): the source going inactive sets a latched request; the source going active does not.
- R11: Sensitivity 10 (low level): `irq_o` follows the active source with no latching. The request drops when the source goes inactive, and the clear bit has no effect on it.
- R12: Sensitivity 11 (both): either transition of the source sets a latched request.
- R13: A write to address 3 with bit 7 = 1 clears a latched request. A write with bit 7 = 0 leaves it set. If a new event arrives in the same cycle as the clear, the event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data (combinational on addr) |
| pin_i | input | 8 | Pad input levels |
| alt_en_i | input | 8 | Per-pin alternate-function enable |
| alt_out_i | input | 8 | Per-pin alternate output value |
| pad_oe_o | output | 8 | Per-pin output enable |
| pad_out_o | output | 8 | Per-pin output value |
| pad_pu_o | output | 8 | Per-pin pull-up enable |
| irq_o | output | 1 | Shared interrupt request |

## Verification
The hardest case to reach is a sensitivity that must ignore one direction of the shared source. It needs an enabled pin to fall and then rise again while a latched request stays intact or stays absent. The configuration writes themselves can fire a spurious event. The stimulus therefore holds every pad high while it configures, clears any pending request, and only then toggles a single enabled pin. It waits past the synchronizer and the latch stage before each sample. The same sequence runs on a disabled pin and on an alternate-function pin, which shows that neither moves the request.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W   = 2;
  localparam int REG_W    = 8;
  localparam int CLR_BIT  = 7;

  localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] A_DIR  = 2'd1;
  localparam logic [ADDR_W-1:0] A_OPT  = 2'd2;
  localparam logic [ADDR_W-1:0] A_IRQ  = 2'd3;

  typedef enum logic [1:0] {
    SENS_FALL = 2'b00,
    SENS_RISE = 2'b01,
    SENS_LOW  = 2'b10,
    SENS_BOTH = 2'b11
  } sens_e;

  typedef enum logic [1:0] {
    PM_FLOAT  = 2'b00,
    PM_PULLUP = 2'b01,
    PM_OPEN   = 2'b10,
    PM_PUSH   = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dir_i,
  input  logic opt_i,
  input  logic dat_i,
  input  logic alt_en_i,
  input  logic alt_out_i,
  input  logic pin_s_i,
  output logic oe_o,
  output logic out_o,
  output logic pu_o,
  output logic irq_en_o,
  output logic rd_o
);
  pin_mode_e mode;

  always_comb begin
    mode     = pin_mode_e'({dir_i, opt_i});
    oe_o     = 1'b0;
    out_o    = 1'b0;
    pu_o     = 1'b0;
    irq_en_o = 1'b0;
    rd_o     = pin_s_i;
    if (alt_en_i) begin
      oe_o  = 1'b1;
      out_o = alt_out_i;
      rd_o  = alt_out_i;
    end else begin
      unique case (mode)
        PM_FLOAT:  ;
        PM_PULLUP: begin
          pu_o     = 1'b1;
          irq_en_o = 1'b1;
        end
        PM_OPEN: begin
          oe_o = ~dat_i;
          rd_o = dat_i;
        end
        PM_PUSH: begin
          oe_o  = 1'b1;
          out_o = dat_i;
          rd_o  = dat_i;
        end
        default: ;
      endcase
    end
  end

  // R2: floating input neither drives nor pulls nor interrupts
  p_float_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_i && !opt_i && !alt_en_i) |-> (!oe_o && !pu_o && !irq_en_o));

  // R4: open-drain output never drives a high level
  p_od_no_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_i && !opt_i && !alt_en_i) |-> !(oe_o && out_o));

  // R6: alternate pin drives and is dropped from the interrupt
  p_alt_owns_r6: assert property (@(posedge clk) disable iff (!rst_n)
    alt_en_i |-> (oe_o && !pu_o && !irq_en_o));
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq
  import gpio_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  src_i,
  input  sens_e sens_i,
  input  logic  clr_i,
  output logic  irq_o
);
  logic src_q;
  logic pend_q;
  logic went_act;
  logic went_idle;
  logic set_evt;

  assign went_act  = src_i & ~src_q;
  assign went_idle = ~src_i & src_q;

  always_comb begin
    unique case (sens_i)
      SENS_FALL: set_evt = went_act;
      SENS_RISE: set_evt = went_idle;
      SENS_BOTH: set_evt = went_act | went_idle;
      default:   set_evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      src_q <= src_i;
      if (set_evt)    pend_q <= 1'b1;
      else if (clr_i) pend_q <= 1'b0;
    end
  end

  assign irq_o = (sens_i == SENS_LOW) ? src_i : pend_q;

  // R13: clear without a simultaneous event empties the latch
  p_clear_works_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_evt) |=> !pend_q);

  // R13: latched request persists until cleared
  p_pend_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr_i) |=> pend_q);

  // R9: falling sensitivity latches when the source becomes active
  p_fall_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sens_i == SENS_FALL && src_i && !$past(src_i)) |=> pend_q);

  // R11: low-level mode never reports while the source is idle
  p_level_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sens_i == SENS_LOW && !src_i) |-> !irq_o);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] alt_en_i,
  input  logic [NPINS-1:0] alt_out_i,
  output logic [NPINS-1:0] pad_oe_o,
  output logic [NPINS-1:0] pad_out_o,
  output logic [NPINS-1:0] pad_pu_o,
  output logic             irq_o
);
  localparam int SENS_W = 2;

  logic [NPINS-1:0] dat_q, dir_q, opt_q;
  sens_e            sens_q;
  logic [NPINS-1:0] pin_s;
  logic [NPINS-1:0] irq_en;
  logic [NPINS-1:0] rd_val;
  logic             src_low;
  logic             clr_pulse;
  logic             wr_irq;

  assign wr_irq    = wr_en && (addr == A_IRQ);
  assign clr_pulse = wr_irq && wdata[CLR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q  <= '0;
      dir_q  <= '0;
      opt_q  <= '0;
      sens_q <= SENS_FALL;
    end else if (wr_en) begin
      unique case (addr)
        A_DATA: dat_q  <= wdata[NPINS-1:0];
        A_DIR:  dir_q  <= wdata[NPINS-1:0];
        A_OPT:  opt_q  <= wdata[NPINS-1:0];
        A_IRQ:  sens_q <= sens_e'(wdata[SENS_W-1:0]);
        default: ;
      endcase
    end
  end

  gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
      gpio_pin_cell u_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_i     (dir_q[i]),
        .opt_i     (opt_q[i]),
        .dat_i     (dat_q[i]),
        .alt_en_i  (alt_en_i[i]),
        .alt_out_i (alt_out_i[i]),
        .pin_s_i   (pin_s[i]),
        .oe_o      (pad_oe_o[i]),
        .out_o     (pad_out_o[i]),
        .pu_o      (pad_pu_o[i]),
        .irq_en_o  (irq_en[i]),
        .rd_o      (rd_val[i])
      );
    end
  endgenerate

  assign src_low = |(irq_en & ~pin_s);

  gpio_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (src_low),
    .sens_i (sens_q),
    .clr_i  (clr_pulse),
    .irq_o  (irq_o)
  );

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_DATA: rdata[NPINS-1:0]  = rd_val;
      A_DIR:  rdata[NPINS-1:0]  = dir_q;
      A_OPT:  rdata[NPINS-1:0]  = opt_q;
      A_IRQ:  rdata[SENS_W-1:0] = sens_q;
      default: ;
    endcase
  end

  // R8: with no interrupt-enabled pin the shared source stays idle
  p_no_src_without_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |-> !src_low);
endmodule

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [7:0] pin_i = 8'hFF;
  logic [7:0] alt_en_i = 8'h00;
  logic [7:0] alt_out_i = 8'h00;
  logic [7:0] pad_oe_o, pad_out_o, pad_pu_o;
  logic       irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_port dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_i(pin_i), .alt_en_i(alt_en_i), .alt_out_i(alt_out_i),
    .pad_oe_o(pad_oe_o), .pad_out_o(pad_out_o), .pad_pu_o(pad_pu_o),
    .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 1; a < 4; a++) begin
      rd(a[1:0], v);
      check("R1 reg reset", v, 8'h00);
    end
    check("R1 oe reset", pad_oe_o, 8'h00);
    check("R1 pu reset", pad_pu_o, 8'h00);
    check("R1 irq reset", irq_o, 1'b0);
  endtask

  task automatic t_modes();
    logic [7:0] v;
    wr(2'd0, 8'h18);
    wr(2'd1, 8'h3C);
    wr(2'd2, 8'h32);
    pin_i = 8'hA5;
    settle();
    check("R2 R3 R4 R5 oe", pad_oe_o, 8'h34);
    check("R4 R5 out", pad_out_o, 8'h10);
    check("R2 R3 R5 pu", pad_pu_o, 8'h02);
    rd(2'd0, v);
    check("R7 data readback", v, 8'h99);
    rd(2'd1, v);
    check("R7 dir readback", v, 8'h3C);
    rd(2'd2, v);
    check("R7 opt readback", v, 8'h32);
    wr(2'd0, 8'h04);
    check("R4 od released", pad_oe_o[2], 1'b0);
  endtask

  task automatic t_alt();
    logic [7:0] v;
    alt_en_i = 8'h40; alt_out_i = 8'h40;
    @(negedge clk);
    check("R6 alt oe", pad_oe_o[6], 1'b1);
    check("R6 alt out", pad_out_o[6], 1'b1);
    check("R6 alt pu", pad_pu_o[6], 1'b0);
    rd(2'd0, v);
    check("R7 alt readback", v[6], 1'b1);
  endtask

  task automatic irq_setup();
    pin_i = 8'hFF;
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h4F);
    settle();
    wr(2'd3, 8'h80);
    settle();
  endtask

  task automatic t_fall();
    logic [7:0] v;
    check("R9 idle", irq_o, 1'b0);
    pin_i[5] = 1'b0; settle();
    check("R2 disabled pin ignored", irq_o, 1'b0);
    pin_i[5] = 1'b1;
    pin_i[6] = 1'b0; settle();
    check("R6 alt pin ignored", irq_o, 1'b0);
    pin_i[6] = 1'b1; settle();
    pin_i[2] = 1'b0; settle();
    check("R8 R9 fall latches", irq_o, 1'b1);
    pin_i[2] = 1'b1; settle();
    check("R9 stays latched", irq_o, 1'b1);
    wr(2'd3, 8'h03);
    rd(2'd3, v);
    check("R7 irq ctrl readback", v, 8'h03);
    check("R13 no-clear write keeps", irq_o, 1'b1);
    wr(2'd3, 8'h80); @(negedge clk);
    check("R13 clear", irq_o, 1'b0);
  endtask

  task automatic t_rise();
    wr(2'd3, 8'h81); settle();
    pin_i[2] = 1'b0; settle();
    check("R10 active edge ignored", irq_o, 1'b0);
    pin_i[2] = 1'b1; settle();
    check("R10 rise latches", irq_o, 1'b1);
    wr(2'd3, 8'h81); @(negedge clk);
    check("R10 R13 clear", irq_o, 1'b0);
  endtask

  task automatic t_level();
    wr(2'd3, 8'h82); settle();
    check("R11 idle", irq_o, 1'b0);
    pin_i[1] = 1'b0; settle();
    check("R11 level high", irq_o, 1'b1);
    wr(2'd3, 8'h82); @(negedge clk);
    check("R11 clear no effect", irq_o, 1'b1);
    pin_i[1] = 1'b1; settle();
    check("R11 level drops", irq_o, 1'b0);
  endtask

  task automatic t_both();
    wr(2'd3, 8'h83); settle();
    pin_i[3] = 1'b0; settle();
    check("R12 active edge", irq_o, 1'b1);
    wr(2'd3, 8'h83); @(negedge clk);
    check("R12 cleared", irq_o, 1'b0);
    pin_i[3] = 1'b1; settle();
    check("R12 release edge", irq_o, 1'b1);
    wr(2'd3, 8'h83); @(negedge clk);
    check("R12 R13 final clear", irq_o, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_alt();
    irq_setup();
    t_fall();
    t_rise();
    t_level();
    t_both();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule